// File: doc/BRIEF.md
# 1-Wire Slave Addressing Layer (ROM Command Processor)

This block is the device-selection stage of a single-wire slave. A separate slot-timing front end turns bus activity into three kinds of events: a reset/presence event, a bit written by the master, and a request for the slave to supply one read bit. After every reset event the block collects an 8-bit command, least significant bit first. Depending on the code it streams the 64-bit device identifier, compares the master's identifier against its own, takes part in the bit-by-bit search tree, or skips addressing. Whenever addressing succeeds it raises a grant level that hands the bus to the memory function unit until the next reset event.

A resume flag survives reset events. Only a completed match or a completed search sets it, and any of the read, match, search or skip commands clears it, so a later resume command grants access again only while this device was the last one to be selected. A combinational check also reports whether the identifier's top byte is the correct 8-bit CRC of its lower 56 bits.

Top module: `onew_rom_ctrl`

## Requirements
- R1: A pulse on `bus_reset` drops `mem_grant` and starts a new 8-bit command, received least significant bit first. It also overrides any command that is half received. While the command is collected, `tx_bit` is 1 (released).
- R2: Command 33h streams `dev_id` on `tx_bit`, bit 0 first. Each `tx_req` pulse advances to the next bit. After the 64th pulse `mem_grant` rises.
- R3: Command 55h is followed by 64 written bits. If all 64 equal `dev_id`, bit 0 first, `mem_grant` rises and the resume flag is set.
- R4: During a match, the first bit that differs from `dev_id` sends the block idle. `tx_bit` then stays 1, `mem_grant` stays low and later bits are ignored until `bus_reset`.
- R5: Command F0h handles each identifier bit, from bit 0 upward, as a triplet. The first read slot gives the true bit. The second read slot gives its complement. Then one written bit carries the master's choice.
- R6: During a search, a chosen bit that differs from the device's own bit sends the block idle until `bus_reset`.
- R7: When the chosen bit of all 64 search triplets matches, `mem_grant` rises and the resume flag is set.
- R8: Command CCh raises `mem_grant` without setting the resume flag.
- R9: Command A5h raises `mem_grant` if the resume flag is set. If the flag is clear, it sends the block idle.
- R10: Receiving 33h, 55h, F0h or CCh clears the resume flag, even if the addressing that follows then fails.
- R11: Any other command code sends the block idle. While idle, `tx_bit` is 1 and read requests have no effect.
- R12: `mem_grant` rises on the clock edge that takes the final bit event, and it holds until `bus_reset`. `tx_bit` is combinational from the internal state.
- R13: `id_crc_ok` is 1 exactly when `dev_id[63:56]` equals the CRC of `dev_id[55:0]`. The CRC uses x^8+x^5+x^4+1, starts from zero, and takes the bits LSB first.
- R14: `rst_n` low clears the resume flag and leaves the block idle, with `mem_grant` low and `tx_bit` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | One-cycle pulse: the bus reset/presence sequence has ended |
| rx_valid | input | 1 | One-cycle pulse: the master wrote a bit |
| rx_bit | input | 1 | Value of the written bit |
| tx_req | input | 1 | One-cycle pulse: the read slot using `tx_bit` is consumed |
| dev_id | input | 64 | Device identifier: family byte low, serial, CRC byte high |
| tx_bit | output | 1 | Bit to present in the current read slot (1 = release) |
| mem_grant | output | 1 | Memory functions may use the bus |
| id_crc_ok | output | 1 | The identifier's CRC byte is consistent |

## Verification
Every event advances the state on the clock edge that samples it. So `mem_grant` and the next `tx_bit` are valid one edge after the final bit event, and `tx_bit` for a read slot is already valid before its `tx_req` pulse. `id_crc_ok` responds to `dev_id` within the same cycle. The bench drives each event on a falling edge and holds it for one rising edge. It updates its behavioural model just after that rising edge, and it compares both outputs with the model on every falling edge, away from the active edge. Named checks read the streamed and search bits before each read pulse, and they test the resume flag only through later resume commands.

// File: rtl/onew_rom_pkg.sv
package onew_rom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_SRCH,
        ST_GRANT
    } rom_state_e;

    typedef enum logic [1:0] {
        PH_TRUE,
        PH_CPL,
        PH_DIR
    } srch_phase_e;

    localparam int CODE_BITS = 8;

    localparam logic [CODE_BITS-1:0] CODE_READ_ID  = 8'h33;
    localparam logic [CODE_BITS-1:0] CODE_MATCH_ID = 8'h55;
    localparam logic [CODE_BITS-1:0] CODE_SEARCH   = 8'hF0;
    localparam logic [CODE_BITS-1:0] CODE_SKIP     = 8'hCC;
    localparam logic [CODE_BITS-1:0] CODE_RESUME   = 8'hA5;

    // x^8 + x^5 + x^4 + 1, reflected for LSB-first shifting
    localparam logic [7:0] CRC8_POLY_REFL = 8'h8C;

endpackage

// File: rtl/onew_rom_bitsel.sv
module onew_rom_bitsel #(
    parameter int VEC_BITS = 64,
    parameter int SEL_W    = $clog2(VEC_BITS)
) (
    input  logic [VEC_BITS-1:0] vec,
    input  logic [SEL_W-1:0]    sel,
    input  logic                cand,
    output logic                bit_o,
    output logic                differs
);
    assign bit_o   = vec[sel];
    assign differs = (cand != vec[sel]);
endmodule

// File: rtl/onew_rom_crc8.sv
module onew_rom_crc8 #(
    parameter int         DATA_BITS = 56,
    parameter int         CRC_BITS  = 8,
    parameter logic [7:0] POLY      = 8'h8C
) (
    input  logic [DATA_BITS+CRC_BITS-1:0] word,
    output logic                          ok
);
    localparam int WORD_BITS = DATA_BITS + CRC_BITS;

    logic [CRC_BITS-1:0] acc;

    always_comb begin
        logic fb;
        acc = '0;
        for (int i = 0; i < DATA_BITS; i++) begin
            fb  = acc[0] ^ word[i];
            acc = acc >> 1;
            if (fb) begin
                acc = acc ^ POLY[CRC_BITS-1:0];
            end
        end
        ok = (acc == word[WORD_BITS-1:DATA_BITS]);
    end
endmodule

// File: rtl/onew_rom_decode.sv
module onew_rom_decode
    import onew_rom_pkg::*;
(
    input  logic [CODE_BITS-1:0] code,
    input  logic                 rc_set,
    output rom_state_e           next_st,
    output logic                 clr_rc
);
    always_comb begin
        clr_rc  = 1'b1;
        next_st = ST_IDLE;
        unique case (code)
            CODE_READ_ID:  next_st = ST_READ;
            CODE_MATCH_ID: next_st = ST_MATCH;
            CODE_SEARCH:   next_st = ST_SRCH;
            CODE_SKIP:     next_st = ST_GRANT;
            CODE_RESUME: begin
                clr_rc  = 1'b0;
                next_st = rc_set ? ST_GRANT : ST_IDLE;
            end
            default: begin
                clr_rc  = 1'b0;
                next_st = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/onew_rom_ctrl.sv
module onew_rom_ctrl
    import onew_rom_pkg::*;
#(
    parameter int ID_BITS  = 64,
    parameter int CRC_BITS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_reset,
    input  logic               rx_valid,
    input  logic               rx_bit,
    input  logic               tx_req,
    input  logic [ID_BITS-1:0] dev_id,
    output logic               tx_bit,
    output logic               mem_grant,
    output logic               id_crc_ok
);
    localparam int IDX_W    = $clog2(ID_BITS);
    localparam int CNT_W    = $clog2(CODE_BITS);
    localparam int SH_BITS  = CODE_BITS - 1;
    localparam int PAY_BITS = ID_BITS - CRC_BITS;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CODE_BITS - 1);

    typedef struct packed {
        rom_state_e         st;
        srch_phase_e        ph;
        logic [IDX_W-1:0]   idx;
        logic [SH_BITS-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic               rc;
    } ctx_t;

    localparam ctx_t CTX_RST = '{
        st:  ST_IDLE,
        ph:  PH_TRUE,
        idx: '0,
        sh:  '0,
        cnt: '0,
        rc:  1'b0
    };

    ctx_t ctx_d, ctx_q;

    logic                 own_bit;
    logic                 bit_differs;
    logic                 idx_last;
    logic [CODE_BITS-1:0] code_full;
    rom_state_e           dec_st;
    logic                 dec_clr;

    // signals seen by the bound checker
    rom_state_e           cur_st;
    logic                 rc_flag;

    assign idx_last  = (ctx_q.idx == LAST_IDX);
    assign code_full = {rx_bit, ctx_q.sh};
    assign cur_st    = ctx_q.st;
    assign rc_flag   = ctx_q.rc;

    onew_rom_bitsel #(
        .VEC_BITS (ID_BITS),
        .SEL_W    (IDX_W)
    ) u_bitsel (
        .vec     (dev_id),
        .sel     (ctx_q.idx),
        .cand    (rx_bit),
        .bit_o   (own_bit),
        .differs (bit_differs)
    );

    onew_rom_decode u_decode (
        .code    (code_full),
        .rc_set  (ctx_q.rc),
        .next_st (dec_st),
        .clr_rc  (dec_clr)
    );

    onew_rom_crc8 #(
        .DATA_BITS (PAY_BITS),
        .CRC_BITS  (CRC_BITS),
        .POLY      (CRC8_POLY_REFL)
    ) u_crc (
        .word (dev_id),
        .ok   (id_crc_ok)
    );

    // next-state computation
    always_comb begin
        ctx_d = ctx_q;
        if (bus_reset) begin
            ctx_d.st  = ST_CMD;
            ctx_d.ph  = PH_TRUE;
            ctx_d.idx = '0;
            ctx_d.cnt = '0;
        end else begin
            unique case (ctx_q.st)
                ST_CMD: begin
                    if (rx_valid) begin
                        ctx_d.sh  = code_full[CODE_BITS-1:1];
                        ctx_d.cnt = ctx_q.cnt + 1'b1;
                        if (ctx_q.cnt == LAST_CNT) begin
                            ctx_d.st  = dec_st;
                            ctx_d.idx = '0;
                            ctx_d.ph  = PH_TRUE;
                            if (dec_clr) begin
                                ctx_d.rc = 1'b0;
                            end
                        end
                    end
                end
                ST_READ: begin
                    if (tx_req) begin
                        if (idx_last) begin
                            ctx_d.st = ST_GRANT;
                        end else begin
                            ctx_d.idx = ctx_q.idx + 1'b1;
                        end
                    end
                end
                ST_MATCH: begin
                    if (rx_valid) begin
                        if (bit_differs) begin
                            ctx_d.st = ST_IDLE;
                        end else if (idx_last) begin
                            ctx_d.st = ST_GRANT;
                            ctx_d.rc = 1'b1;
                        end else begin
                            ctx_d.idx = ctx_q.idx + 1'b1;
                        end
                    end
                end
                ST_SRCH: begin
                    unique case (ctx_q.ph)
                        PH_TRUE: if (tx_req) ctx_d.ph = PH_CPL;
                        PH_CPL:  if (tx_req) ctx_d.ph = PH_DIR;
                        default: begin
                            if (rx_valid) begin
                                if (bit_differs) begin
                                    ctx_d.st = ST_IDLE;
                                end else if (idx_last) begin
                                    ctx_d.st = ST_GRANT;
                                    ctx_d.rc = 1'b1;
                                end else begin
                                    ctx_d.idx = ctx_q.idx + 1'b1;
                                    ctx_d.ph  = PH_TRUE;
                                end
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= CTX_RST;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    // outputs
    always_comb begin
        tx_bit = 1'b1;
        unique case (ctx_q.st)
            ST_READ: tx_bit = own_bit;
            ST_SRCH: begin
                if (ctx_q.ph == PH_TRUE) begin
                    tx_bit = own_bit;
                end else if (ctx_q.ph == PH_CPL) begin
                    tx_bit = ~own_bit;
                end
            end
            default: tx_bit = 1'b1;
        endcase
    end

    assign mem_grant = (ctx_q.st == ST_GRANT);

endmodule

// File: rtl/onew_rom_ctrl_chk.sv
module onew_rom_ctrl_chk
    import onew_rom_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       bus_reset,
    input logic       rx_valid,
    input logic       tx_req,
    input logic       tx_bit,
    input logic       mem_grant,
    input logic       rc_flag,
    input rom_state_e cur_st
);
    AST_GRANT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_grant && !bus_reset) |=> mem_grant); // R12

    AST_GRANT_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_grant) |-> $past(rx_valid || tx_req)); // R12

    AST_BUSRST_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!mem_grant && cur_st == ST_CMD)); // R1

    AST_CMD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_CMD) |-> (tx_bit && !mem_grant)); // R1

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_IDLE) |-> (tx_bit && !mem_grant)); // R11

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_st == ST_IDLE && !bus_reset) |=> (cur_st == ST_IDLE)); // R4

    AST_RC_RISE_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rc_flag) |-> mem_grant); // R3
endmodule

bind onew_rom_ctrl onew_rom_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .rx_valid  (rx_valid),
    .tx_req    (tx_req),
    .tx_bit    (tx_bit),
    .mem_grant (mem_grant),
    .rc_flag   (rc_flag),
    .cur_st    (cur_st)
);

// File: tb/onew_rom_ctrl_tb_top.sv
`timescale 1ns/1ps
module onew_rom_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_bit = 1'b0;
    logic        tx_req = 1'b0;
    logic [63:0] dev_id;
    logic        tx_bit, mem_grant, id_crc_ok;

    always #4 clk = ~clk;

    onew_rom_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_bit(rx_bit), .tx_req(tx_req), .dev_id(dev_id),
        .tx_bit(tx_bit), .mem_grant(mem_grant), .id_crc_ok(id_crc_ok)
    );

    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    bit    cmp_on = 0;
    string cur_req = "R14";

    // behavioural reference: 0 idle, 1 command, 2 read, 3 match, 4 search, 5 granted
    int         m_mode = 0;
    int         m_idx = 0;
    int         m_ph = 0;
    int         m_cnt = 0;
    logic [7:0] m_code = 8'h00;
    bit         m_rc = 0;

    function automatic logic [7:0] crc_of(input logic [63:0] v, input int n);
        logic [7:0] r = 8'h00;
        for (int i = 0; i < n; i++) begin
            logic fb = r[0] ^ v[i];
            r = {fb, r[7], r[6], r[5], r[4] ^ fb, r[3] ^ fb, r[2], r[1]};
        end
        return r;
    endfunction

    function automatic logic m_tx();
        if (m_mode == 2) return dev_id[m_idx];
        if (m_mode == 4 && m_ph == 0) return dev_id[m_idx];
        if (m_mode == 4 && m_ph == 1) return ~dev_id[m_idx];
        return 1'b1;
    endfunction

    task automatic check(input logic act, input logic exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            total++;
            if (mem_grant !== (m_mode == 5) || tx_bit !== m_tx()) begin
                bad++;
                $display("FAIL %s per-cycle: actual grant=%b tx=%b expected grant=%b tx=%b",
                         cur_req, mem_grant, tx_bit, (m_mode == 5), m_tx());
            end
        end
    end

    task automatic model_rx(input logic b);
        case (m_mode)
            1: begin
                m_code = {b, m_code[7:1]};
                m_cnt++;
                if (m_cnt == 8) begin
                    m_idx = 0; m_ph = 0;
                    case (m_code)
                        8'h33: begin m_rc = 0; m_mode = 2; end
                        8'h55: begin m_rc = 0; m_mode = 3; end
                        8'hF0: begin m_rc = 0; m_mode = 4; end
                        8'hCC: begin m_rc = 0; m_mode = 5; end
                        8'hA5: m_mode = m_rc ? 5 : 0;
                        default: m_mode = 0;
                    endcase
                end
            end
            3, 4: begin
                if (m_mode == 3 || m_ph == 2) begin
                    if (b !== dev_id[m_idx]) m_mode = 0;
                    else if (m_idx == 63) begin m_mode = 5; m_rc = 1; end
                    else begin m_idx++; m_ph = 0; end
                end
            end
            default: ;
        endcase
    endtask

    task automatic model_tx();
        if (m_mode == 2) begin
            if (m_idx == 63) m_mode = 5; else m_idx++;
        end else if (m_mode == 4 && m_ph < 2) begin
            m_ph++;
        end
    endtask

    task automatic do_busrst();
        @(negedge clk); bus_reset = 1'b1;
        @(posedge clk); #1 bus_reset = 1'b0;
        m_mode = 1; m_cnt = 0; m_idx = 0; m_ph = 0;
    endtask

    task automatic do_rx(input logic b);
        @(negedge clk); rx_valid = 1'b1; rx_bit = b;
        @(posedge clk); #1 rx_valid = 1'b0; rx_bit = 1'b0;
        model_rx(b);
    endtask

    task automatic do_tx();
        @(negedge clk); tx_req = 1'b1;
        @(posedge clk); #1 tx_req = 1'b0;
        model_tx();
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) do_rx(v[i]);
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    localparam logic [55:0] PAYLOAD = {48'h1A2B3C4D5E6F, 8'h0D};
    logic [63:0] good_id;

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [63:0] rd;
        good_id = {crc_of({8'h00, PAYLOAD}, 56), PAYLOAD};
        dev_id  = good_id;
        idle_cycles(3);
        #1;
        // R14: reset state
        check(mem_grant, 1'b0, "R14", "grant in reset");
        check(tx_bit, 1'b1, "R14", "tx in reset");
        rst_n = 1'b1;
        idle_cycles(2);
        cmp_on = 1;

        // R13: CRC consistency
        check(id_crc_ok, 1'b1, "R13", "good id crc");
        check(crc_of(good_id, 64) == 8'h00, 1'b1, "R13", "residue zero");
        @(negedge clk); cmp_on = 0; dev_id = good_id ^ 64'h0000_0000_0100_0000; #1;
        check(id_crc_ok, 1'b0, "R13", "corrupted id crc");
        dev_id = good_id; #1;
        @(negedge clk); cmp_on = 1;

        // R1: aborted command is restarted by a bus reset
        cur_req = "R1";
        do_busrst();
        check(tx_bit, 1'b1, "R1", "tx while collecting");
        send_byte(8'hFF);
        do_busrst();
        for (int i = 0; i < 4; i++) do_rx(1'b1);
        do_busrst();
        check(mem_grant, 1'b0, "R1", "grant after restart");

        // R2: read identifier
        cur_req = "R2";
        send_byte(8'h33);
        rd = '0;
        for (int i = 0; i < 64; i++) begin
            rd[i] = tx_bit;
            check(mem_grant, 1'b0, "R2", "grant during read");
            do_tx();
        end
        check(rd == good_id, 1'b1, "R2", "streamed id equals dev_id");
        check(mem_grant, 1'b1, "R2", "grant after 64 reads");

        // R12: grant held
        cur_req = "R12";
        idle_cycles(5);
        check(mem_grant, 1'b1, "R12", "grant held");
        do_rx(1'b0); do_tx();
        check(mem_grant, 1'b1, "R12", "grant held over events");

        // R3 + R9: match then resume
        cur_req = "R3";
        do_busrst();
        send_byte(8'h55);
        for (int i = 0; i < 64; i++) do_rx(good_id[i]);
        check(mem_grant, 1'b1, "R3", "grant after full match");
        cur_req = "R9";
        do_busrst();
        send_byte(8'hA5);
        check(mem_grant, 1'b1, "R9", "resume with flag set");

        // R8 + R10: skip clears the flag, resume then fails
        cur_req = "R8";
        do_busrst();
        send_byte(8'hCC);
        check(mem_grant, 1'b1, "R8", "grant after skip");
        cur_req = "R10";
        do_busrst();
        send_byte(8'hA5);
        check(mem_grant, 1'b0, "R10", "resume after skip refused");
        check(tx_bit, 1'b1, "R9", "idle after refused resume");
        do_tx();
        check(tx_bit, 1'b1, "R11", "idle read request released");

        // R4: mismatch at bit 10, rest ignored; then R10 via failed match
        cur_req = "R4";
        do_busrst(); send_byte(8'h55);
        for (int i = 0; i < 64; i++) do_rx(good_id[i]);   // set flag
        do_busrst(); send_byte(8'h55);
        for (int i = 0; i < 64; i++) do_rx(i == 10 ? ~good_id[i] : good_id[i]);
        check(mem_grant, 1'b0, "R4", "no grant after mismatch");
        check(tx_bit, 1'b1, "R4", "released after mismatch");
        do_busrst(); send_byte(8'hA5);
        check(mem_grant, 1'b0, "R10", "failed match cleared flag");

        // R5 + R7: full search
        cur_req = "R5";
        do_busrst(); send_byte(8'hF0);
        for (int i = 0; i < 64; i++) begin
            check(tx_bit, good_id[i], "R5", "search true bit");
            do_tx();
            check(tx_bit, ~good_id[i], "R5", "search complement bit");
            do_tx();
            do_rx(good_id[i]);
        end
        cur_req = "R7";
        check(mem_grant, 1'b1, "R7", "grant after search");
        do_busrst(); send_byte(8'hA5);
        check(mem_grant, 1'b1, "R7", "search set resume flag");

        // R6: search drop-out at bit 5
        cur_req = "R6";
        do_busrst(); send_byte(8'hF0);
        for (int i = 0; i < 6; i++) begin
            do_tx(); do_tx();
            do_rx(i == 5 ? ~good_id[i] : good_id[i]);
        end
        check(tx_bit, 1'b1, "R6", "released after drop-out");
        do_tx(); do_tx(); do_rx(good_id[6]);
        check(mem_grant, 1'b0, "R6", "no grant after drop-out");

        // R11: unknown command
        cur_req = "R11";
        do_busrst(); send_byte(8'h96);
        check(tx_bit, 1'b1, "R11", "unknown code idles");
        check(mem_grant, 1'b0, "R11", "unknown code no grant");

        // R14: reset clears the flag
        cur_req = "R14";
        do_busrst(); send_byte(8'h55);
        for (int i = 0; i < 64; i++) do_rx(good_id[i]);
        @(negedge clk); cmp_on = 0; rst_n = 1'b0;
        idle_cycles(2);
        check(mem_grant, 1'b0, "R14", "grant in reset");
        @(negedge clk); rst_n = 1'b1;
        m_mode = 0; m_rc = 0;
        idle_cycles(1);
        cmp_on = 1;
        do_busrst(); send_byte(8'hA5);
        check(mem_grant, 1'b0, "R14", "flag cleared by reset");

        idle_cycles(2);
        finish_run();
    end
endmodule